// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that lets an external bus master read and write a small bank of byte registers. It runs on a fast system clock and samples the bus lines SCL and SDA through two-flop synchronisers. It never drives a line high. It pulls SDA low through an output enable, and the pad is expected to be open-drain with a pull-up.

A master selects a register by writing a pointer byte right after the address byte of a write transaction. Any data bytes that follow land at the pointer, and the pointer moves on by one after each byte. To read, the master writes only the pointer, issues a repeated START with the read bit, and then clocks bytes out. It acknowledges each byte it wants to continue with and leaves the last one unacknowledged.

A simple internal port can write the bank whenever the bus is idle, and it can read any register at any time.

Top module: `i2c_tgt_top`

## Requirements
- R1: A START (synchronised SDA falling while synchronised SCL is high) makes `busBusy` 1. A STOP (SDA rising while SCL is high) returns it to 0. `sdaOe` is never asserted while `busBusy` is 0.
- R2: The first byte after a START is received MSB first. Its upper seven bits are the device address and bit 0 is the direction (0 = write, 1 = read). On a match, the target holds SDA low during the 9th SCL clock.
- R3: If the address does not match, the target leaves SDA high on the 9th clock and ignores all bytes until the next START, so no register changes.
- R4: In a write, the byte after the address acknowledge loads the register pointer from its low four bits. The next byte is stored at that pointer and is acknowledged.
- R5: Further write bytes without a STOP go to consecutive registers, each acknowledged.
- R6: After a pointer write, a repeated START and a matching address with bit 0 = 1, the target acknowledges and shifts out the register at the pointer, MSB first, changing SDA while SCL is low.
- R7: Each byte the master acknowledges (SDA low on the 9th clock) is followed by the next register. After a byte the master does not acknowledge, the target releases SDA until the next START. The pointer ends one past the last byte sent.
- R8: The pointer wraps from register 15 to register 0 in both writes and reads.
- R9: A repeated START in the middle of a byte aborts that byte without writing it, returns the target to address reception, and keeps the pointer.
- R10: When `busBusy` is 0, `hostWe` writes `hostWdata` to register `hostAddr`, and the value is visible on `hostRdata` on the next cycle. When `busBusy` is 1, `hostWe` is ignored. `hostRdata` always shows register `hostAddr`.
- R11: `sdaOe` changes only after SCL has been seen low. It never changes while SCL has been high for several cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low |
| busBusy | output | 1 | 1 between a START and the following STOP |
| hostWe | input | 1 | Internal write strobe |
| hostAddr | input | 4 | Internal register index |
| hostWdata | input | 8 | Internal write data |
| hostRdata | output | 8 | Register at `hostAddr` |

## Verification
The hardest case to reach is a repeated START that lands partway through a data byte after the pointer has already been set. It must throw away the partial bits and keep the pointer. The bench reaches it by writing the pointer, clocking in three data bits, and then raising SCL with SDA released so that a fourth bit is shifted in before SDA falls. A read then shows that the pointed register still holds its old value. The pointer's position after a master NACK is observed by starting a fresh read without a pointer write.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BYTE_IN, ST_EVAL, ST_ACK_WAIT,
    ST_ACK_DRV, ST_BYTE_OUT, ST_HOST_ACK, ST_SKIP
  } tgtState_e;

  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} byteKind_e;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic writeReg;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  output dpStrobe_t         stb,
  output logic              sdaBit,
  output logic              sdaOe,
  output logic              busBusy
);
  logic sclMeta, sclS, sclD, sdaMeta, sdaS, sdaD;
  tgtState_e state, nState;
  byteKind_e kind, nKind;
  logic [2:0] bitCnt, nCnt;
  logic readMode, nRead, masterAck, nMack;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {sclMeta, sclS, sclD} <= 3'b111;
      {sdaMeta, sdaS, sdaD} <= 3'b111;
    end else begin
      {sclMeta, sclS, sclD} <= {sclIn, sclMeta, sclS};
      {sdaMeta, sdaS, sdaD} <= {sdaIn, sdaMeta, sdaS};
    end
  end

  wire sclRise   = sclS & ~sclD;
  wire sclFall   = ~sclS & sclD;
  wire startSeen = sclS & sclD & sdaD & ~sdaS;
  wire stopSeen  = sclS & sclD & ~sdaD & sdaS;
  wire addrHit   = (rxByte[7:1] == DEV_ADDR);

  always_comb begin
    stb    = '0;
    nState = state;
    nKind  = kind;
    nCnt   = bitCnt;
    nRead  = readMode;
    nMack  = masterAck;
    if (startSeen) begin
      nState = ST_BYTE_IN;
      nKind  = K_ADDR;
      nCnt   = '0;
    end else if (stopSeen) begin
      nState = ST_IDLE;
    end else begin
      unique case (state)
        ST_BYTE_IN: if (sclRise) begin
          stb.shiftIn = 1'b1;
          nCnt = bitCnt + 3'd1;
          if (bitCnt == 3'd7) nState = ST_EVAL;
        end
        ST_EVAL: begin
          nState = ST_ACK_WAIT;
          unique case (kind)
            K_ADDR: if (addrHit) nRead = rxByte[0];
                    else nState = ST_SKIP;
            K_PTR:  stb.loadPtr = 1'b1;
            default: begin
              stb.writeReg = 1'b1;
              stb.incPtr   = 1'b1;
            end
          endcase
        end
        ST_ACK_WAIT: if (sclFall) nState = ST_ACK_DRV;
        ST_ACK_DRV: if (sclFall) begin
          nCnt = '0;
          if (kind == K_ADDR && readMode) begin
            stb.loadTx = 1'b1;
            nState = ST_BYTE_OUT;
          end else begin
            nState = ST_BYTE_IN;
            nKind  = (kind == K_ADDR) ? K_PTR : K_DATA;
          end
        end
        ST_BYTE_OUT: if (sclFall) begin
          stb.shiftTx = 1'b1;
          nCnt = bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            stb.incPtr = 1'b1;
            nState = ST_HOST_ACK;
          end
        end
        ST_HOST_ACK: begin
          if (sclRise) nMack = ~sdaS;
          if (sclFall) begin
            if (masterAck) begin
              stb.loadTx = 1'b1;
              nCnt = '0;
              nState = ST_BYTE_OUT;
            end else begin
              nState = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= K_ADDR;
      bitCnt    <= '0;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= nState;
      kind      <= nKind;
      bitCnt    <= nCnt;
      readMode  <= nRead;
      masterAck <= nMack;
    end
  end

  assign sdaBit  = sdaS;
  assign sdaOe   = (state == ST_ACK_DRV) | ((state == ST_BYTE_OUT) & ~txBit);
  assign busBusy = (state != ST_IDLE);
endmodule

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int REG_CNT = 16,
  localparam int PTR_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaBit,
  input  logic              hostEn,
  input  logic              hostWe,
  input  logic [PTR_W-1:0]  hostAddr,
  input  logic [BYTE_W-1:0] hostWdata,
  output logic [BYTE_W-1:0] hostRdata,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit
);
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] regVal [REG_CNT];

  for (genvar gi = 0; gi < REG_CNT; gi++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= '0;
      else if (stb.writeReg && ptr == PTR_W'(gi)) q <= rxByte;
      else if (hostEn && hostWe && hostAddr == PTR_W'(gi)) q <= hostWdata;
    end
    assign regVal[gi] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      rxByte  <= '0;
      txShift <= '0;
    end else begin
      if (stb.shiftIn) rxByte <= {rxByte[BYTE_W-2:0], sdaBit};
      if (stb.loadPtr) ptr <= rxByte[PTR_W-1:0];
      else if (stb.incPtr) ptr <= ptr + PTR_W'(1);
      if (stb.loadTx) txShift <= regVal[ptr];
      else if (stb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  assign txBit     = txShift[BYTE_W-1];
  assign hostRdata = regVal[hostAddr];
endmodule

// File: rtl/i2c_tgt_top.sv
module i2c_tgt_top
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int REG_CNT = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaOe,
  output logic                       busBusy,
  input  logic                       hostWe,
  input  logic [$clog2(REG_CNT)-1:0] hostAddr,
  input  logic [BYTE_W-1:0]          hostWdata,
  output logic [BYTE_W-1:0]          hostRdata
);
  dpStrobe_t         stb;
  logic              sdaBit, txBit;
  logic [BYTE_W-1:0] rxByte;

  i2c_tgt_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txBit(txBit), .stb(stb), .sdaBit(sdaBit),
    .sdaOe(sdaOe), .busBusy(busBusy)
  );

  i2c_tgt_dp #(.REG_CNT(REG_CNT)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaBit),
    .hostEn(~busBusy), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .rxByte(rxByte), .txBit(txBit)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk #(
  parameter int REG_CNT = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       sclIn,
  input logic                       sdaOe,
  input logic                       busBusy,
  input logic                       hostWe,
  input logic [$clog2(REG_CNT)-1:0] hostAddr,
  input logic [7:0]                 hostWdata,
  input logic [7:0]                 hostRdata
);
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !busBusy |-> !sdaOe); // R1

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busBusy) |-> ($past(sclIn, 3) && $past(sclIn, 4))); // R1

  AST_SDA_STILL_HIGH_SCL: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn, 1) && $past(sclIn, 2) && $past(sclIn, 3))
      |-> $stable(sdaOe)); // R11

  AST_HOST_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busBusy && hostWe) |=>
      (!$stable(hostAddr) || hostRdata == $past(hostWdata))); // R10
endmodule

bind i2c_tgt_top i2c_tgt_chk #(.REG_CNT(REG_CNT)) chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .busBusy(busBusy), .hostWe(hostWe), .hostAddr(hostAddr),
  .hostWdata(hostWdata), .hostRdata(hostRdata)
);

// File: tb/i2c_tgt_top_tb_top.sv
module i2c_tgt_top_tb_top;
  localparam logic [6:0] ADDR = 7'h68;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mSclHigh = 1'b1;
  logic mSdaLow = 1'b0;
  logic sdaOe, busBusy, hostWe;
  logic [3:0] hostAddr;
  logic [7:0] hostWdata, hostRdata;
  wire sdaLine = ~(mSdaLow | sdaOe);

  always #2 clk = ~clk;

  i2c_tgt_top #(.DEV_ADDR(ADDR), .REG_CNT(16)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mSclHigh), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .busBusy(busBusy), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  typedef struct { string req; int val; } item_t;
  item_t expQ[$];
  int obsQ[$];
  event obsEv;
  int checks = 0, errors = 0, r11Viol = 0, highCnt = 0;
  logic prevOe = 1'b0;
  bit finished = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pairs observed bus values with expected items
  initial forever begin
    @(obsEv);
    while (obsQ.size() != 0) begin
      int o;
      item_t e;
      o = obsQ.pop_front();
      if (expQ.size() == 0) check("scoreboard underflow", o, -1);
      else begin
        e = expQ.pop_front();
        check(e.req, o, e.val);
      end
    end
  end

  // R11 watch: SDA enable must not move during a long SCL-high phase
  always @(negedge clk) begin
    highCnt = mSclHigh ? highCnt + 1 : 0;
    if (rstN && sdaOe != prevOe && highCnt >= 5) r11Viol++;
    prevOe = sdaOe;
  end

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask
  task automatic mStart(); mSdaLow = 1; waitQ(); mSclHigh = 0; waitQ(); endtask
  task automatic mRestart();
    mSdaLow = 0; waitQ(); mSclHigh = 1; waitQ(); mSdaLow = 1; waitQ();
    mSclHigh = 0; waitQ();
  endtask
  task automatic mStop();
    mSdaLow = 1; waitQ(); mSclHigh = 1; waitQ(); mSdaLow = 0; waitQ(); waitQ();
  endtask
  task automatic mBitW(logic b);
    mSdaLow = ~b; waitQ(); mSclHigh = 1; waitQ(); waitQ(); mSclHigh = 0; waitQ();
  endtask
  task automatic mBitR(output logic b);
    mSdaLow = 0; waitQ(); mSclHigh = 1; waitQ(); b = sdaLine; waitQ();
    mSclHigh = 0; waitQ();
  endtask

  // driver: expAck 1 means the 9th-clock line level should be low
  task automatic sendByte(logic [7:0] v, bit expAck, string req);
    logic b;
    expQ.push_back('{req, expAck ? 0 : 1});
    for (int i = 7; i >= 0; i--) mBitW(v[i]);
    mBitR(b);
    obsQ.push_back(int'(b)); ->obsEv;
  endtask

  task automatic recvByte(logic [7:0] exp, bit ack, string req);
    logic [7:0] v;
    logic b;
    expQ.push_back('{req, int'(exp)});
    for (int i = 7; i >= 0; i--) begin mBitR(b); v[i] = b; end
    obsQ.push_back(int'(v)); ->obsEv;
    mBitW(~ack);
  endtask

  task automatic hostWrite(logic [3:0] a, logic [7:0] d);
    hostAddr = a; hostWdata = d; hostWe = 1; @(negedge clk); hostWe = 0;
  endtask
  task automatic hostCheck(logic [3:0] a, logic [7:0] exp, string req);
    hostAddr = a; @(negedge clk); check(req, int'(hostRdata), int'(exp));
  endtask

  initial begin
    hostWe = 0; hostAddr = 0; hostWdata = 0;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset busy", int'(busBusy), 0);
    check("R1 reset sdaOe", int'(sdaOe), 0);
    hostCheck(4'd9, 8'h00, "R10 reset register");

    hostWrite(4'd3, 8'h3C);
    hostCheck(4'd3, 8'h3C, "R10 host write idle");
    hostWrite(4'd4, 8'h44);
    hostWrite(4'd5, 8'h55);

    // R4 R5 burst write at pointer 2
    mStart();
    check("R1 busy after START", int'(busBusy), 1);
    sendByte({ADDR, 1'b0}, 1, "R2 address ack");
    sendByte(8'h02, 1, "R4 pointer ack");
    sendByte(8'h11, 1, "R4 data ack");
    sendByte(8'h22, 1, "R5 burst data ack");
    mStop();
    check("R1 idle after STOP", int'(busBusy), 0);
    hostCheck(4'd2, 8'h11, "R4 data at pointer");
    hostCheck(4'd3, 8'h22, "R5 next register");

    // R3 foreign address
    mStart();
    sendByte({ADDR ^ 7'h01, 1'b0}, 0, "R3 address nack");
    sendByte(8'h02, 0, "R3 ignored byte");
    sendByte(8'h99, 0, "R3 ignored byte");
    mStop();
    hostCheck(4'd2, 8'h11, "R3 register unchanged");

    // R6 R7 combined read
    mStart();
    sendByte({ADDR, 1'b0}, 1, "R6 address ack");
    sendByte(8'h02, 1, "R6 pointer ack");
    mRestart();
    sendByte({ADDR, 1'b1}, 1, "R6 read address ack");
    recvByte(8'h11, 1, "R6 first read byte");
    recvByte(8'h22, 0, "R7 second read byte");
    check("R7 SDA released after NACK", int'(sdaOe), 0);
    mStop();
    mStart();
    sendByte({ADDR, 1'b1}, 1, "R7 read address ack");
    recvByte(8'h44, 0, "R7 pointer past last byte");
    mStop();

    // R8 wrap
    mStart();
    sendByte({ADDR, 1'b0}, 1, "R8 address ack");
    sendByte(8'h0F, 1, "R8 pointer ack");
    sendByte(8'hF0, 1, "R8 data ack");
    sendByte(8'h0A, 1, "R8 wrapped data ack");
    mStop();
    hostCheck(4'd15, 8'hF0, "R8 last register");
    hostCheck(4'd0, 8'h0A, "R8 wrapped to register 0");
    mStart();
    sendByte({ADDR, 1'b0}, 1, "R8 address ack");
    sendByte(8'h0F, 1, "R8 pointer ack");
    mRestart();
    sendByte({ADDR, 1'b1}, 1, "R8 read address ack");
    recvByte(8'hF0, 1, "R8 read last");
    recvByte(8'h0A, 0, "R8 read wrapped");
    mStop();

    // R9 repeated START inside a data byte
    mStart();
    sendByte({ADDR, 1'b0}, 1, "R9 address ack");
    sendByte(8'h05, 1, "R9 pointer ack");
    mBitW(1'b0); mBitW(1'b0); mBitW(1'b1);
    mRestart();
    sendByte({ADDR, 1'b1}, 1, "R9 read address ack");
    recvByte(8'h55, 0, "R9 pointer kept, byte aborted");
    mStop();
    hostCheck(4'd5, 8'h55, "R9 register unchanged");

    // R10 host write while busy
    mStart();
    sendByte({ADDR, 1'b0}, 1, "R10 address ack");
    hostWrite(4'd7, 8'h77);
    check("R10 busy during host write", int'(busBusy), 1);
    mStop();
    hostCheck(4'd7, 8'h00, "R10 busy write ignored");

    repeat (20) @(negedge clk);
    check("R11 SDA change during SCL high", r11Viol, 0);
    check("scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule